// File: doc/BRIEF.md
# Trap Return Address Register

This block holds the address a supervisor-level trap handler returns to. It takes writes from two directions. A hardware capture port loads the address of the faulting instruction when a trap is taken. A control-register port lets software overwrite the register, or set or clear chosen bits in it. It drives two read views at the same time. One is the value software sees through the control-register read. The other is the return target used by the trap-return instruction.

The block applies the low-bit alignment rules for the instruction alignment mode. A build parameter chooses one of three configurations: fixed 16-bit alignment, fixed 32-bit alignment, or alignment switched at run time. In the switched configuration an input reports whether 32-bit alignment is active at the moment. The compressed-instruction enable drives that input. While 32-bit alignment is active, bit 1 is still stored as written but is hidden from both read views. It reappears once 16-bit alignment returns.

All ports are plain. There is no valid/ready handshake. The register accepts a capture or a software write on every cycle and never applies back-pressure. Both read views are combinational from the stored value.

Top module: `trap_ret_addr`

## Requirements
- R1: After reset the stored value is zero, and both `sw_rdata` and `ret_target` read zero.
- R2: Bit 0 of both read views is always zero, whatever value a capture or a software operation supplies.
- R3: With `ALIGN_CFG = ALN_FIXED32`, bits 1 and 0 of both read views are always zero, and no write can set them.
- R4: With `ALIGN_CFG = ALN_SWITCH` and `align32_on = 1`, bit 1 of `sw_rdata` reads zero. All other bits read as stored.
- R5: `ret_target` always equals `sw_rdata`, so the bit-1 masking also applies to the trap-return target.
- R6: In switched mode, bit 1 can still be written while `align32_on = 1`. Its stored value shows again once `align32_on` returns to 0.
- R7: `sw_op` encoding: 2'b00 makes no change, 2'b01 writes `sw_wdata`, 2'b10 sets the bits that are 1 in `sw_wdata`, and 2'b11 clears the bits that are 1 in `sw_wdata`. Set and clear act on the stored value, including a hidden bit 1.
- R8: When `trap_take` is high, the register loads `trap_pc` (with the legalisation of R2 and R3), and any `sw_op` in the same cycle is ignored.
- R9: A read in the same cycle as a write returns the old value. The new value shows after the next rising clock edge.
- R10: With `ALIGN_CFG = ALN_FIXED16`, bit 1 reads as stored, and `align32_on` has no effect.
- R11: Every bit from `XLEN-1` down to 2 holds any written value (32'hFFFF_FFFE survives a capture).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears the register |
| sw_op | input | 2 | Software operation: 00 none, 01 write, 10 set bits, 11 clear bits |
| sw_wdata | input | XLEN | Software operand |
| sw_rdata | output | XLEN | Software read view (old value in a write cycle) |
| trap_take | input | 1 | Trap capture strobe, wins over `sw_op` |
| trap_pc | input | XLEN | Faulting instruction address to capture |
| align32_on | input | 1 | 32-bit alignment active (used only when `ALIGN_CFG = ALN_SWITCH`) |
| ret_target | output | XLEN | Return address used by the trap-return instruction |

## Verification
The hardest case to reach is a bit 1 that is stored but hidden. To show it was kept, the bench has to write or set bit 1 while 32-bit alignment is active, and the read views must show nothing of it at that time. Then alignment has to drop back to 16-bit with no write in between, and the bit must reappear. The stimulus table does this in order: it writes bit 1 under 32-bit alignment, reads it masked, releases the mode, and then clears and sets bit 1 again while it is hidden. The same stimulus also drives fixed-16 and fixed-32 instances, so one sequence shows all three rule sets side by side.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;
  typedef enum logic [1:0] {
    ALN_FIXED16 = 2'd0,
    ALN_FIXED32 = 2'd1,
    ALN_SWITCH  = 2'd2
  } align_cfg_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } sw_op_e;
endpackage

// File: rtl/trap_ret_next.sv
module trap_ret_next
  import trap_ret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cur_q,
  input  logic [1:0]      sw_op,
  input  logic [XLEN-1:0] sw_wdata,
  input  logic            trap_take,
  input  logic [XLEN-1:0] trap_pc,
  output logic            upd_en,
  output logic [XLEN-1:0] upd_val
);
  sw_op_e op_dec;
  assign op_dec = sw_op_e'(sw_op);

  always_comb begin
    upd_en  = 1'b0;
    upd_val = cur_q;
    if (trap_take) begin
      upd_en  = 1'b1;
      upd_val = trap_pc;
    end else begin
      unique case (op_dec)
        OP_WRITE: begin upd_en = 1'b1; upd_val = sw_wdata;           end
        OP_SET:   begin upd_en = 1'b1; upd_val = cur_q | sw_wdata;   end
        OP_CLEAR: begin upd_en = 1'b1; upd_val = cur_q & ~sw_wdata;  end
        default:  begin upd_en = 1'b0; upd_val = cur_q;              end
      endcase
    end
  end
endmodule

// File: rtl/trap_ret_store.sv
module trap_ret_store
  import trap_ret_pkg::*;
#(
  parameter int         XLEN      = 32,
  parameter align_cfg_e ALIGN_CFG = ALN_SWITCH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [XLEN-1:0] upd_val,
  output logic [XLEN-1:0] q
);
  localparam int LOW_FIXED = (ALIGN_CFG == ALN_FIXED32) ? 2 : 1;

  logic [XLEN-1:LOW_FIXED] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else if (upd_en) hi_q <= upd_val[XLEN-1:LOW_FIXED];
  end

  generate
    if (LOW_FIXED == 2) begin : g_low2
      assign q = {hi_q, 2'b00};
    end else begin : g_low1
      assign q = {hi_q, 1'b0};
    end
  endgenerate

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (q == '0));

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(upd_en)) |-> $stable(q));
endmodule

// File: rtl/trap_ret_view.sv
module trap_ret_view
  import trap_ret_pkg::*;
#(
  parameter int         XLEN      = 32,
  parameter align_cfg_e ALIGN_CFG = ALN_SWITCH
) (
  input  logic [XLEN-1:0] q,
  input  logic            align32_on,
  output logic [XLEN-1:0] view
);
  localparam bit SWITCHED = (ALIGN_CFG == ALN_SWITCH);

  logic hide_b1;
  assign hide_b1 = SWITCHED & align32_on;

  always_comb begin
    view    = q;
    view[0] = 1'b0;
    if (hide_b1) view[1] = 1'b0;
  end
endmodule

// File: rtl/trap_ret_addr.sv
module trap_ret_addr
  import trap_ret_pkg::*;
#(
  parameter int         XLEN      = 32,
  parameter align_cfg_e ALIGN_CFG = ALN_SWITCH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      sw_op,
  input  logic [XLEN-1:0] sw_wdata,
  output logic [XLEN-1:0] sw_rdata,
  input  logic            trap_take,
  input  logic [XLEN-1:0] trap_pc,
  input  logic            align32_on,
  output logic [XLEN-1:0] ret_target
);
  localparam int NVIEW = 2;

  logic            upd_en;
  logic [XLEN-1:0] upd_val;
  logic [XLEN-1:0] q;
  logic [XLEN-1:0] views [NVIEW];

  trap_ret_next #(.XLEN(XLEN)) u_next (
    .cur_q(q), .sw_op(sw_op), .sw_wdata(sw_wdata),
    .trap_take(trap_take), .trap_pc(trap_pc),
    .upd_en(upd_en), .upd_val(upd_val)
  );

  trap_ret_store #(.XLEN(XLEN), .ALIGN_CFG(ALIGN_CFG)) u_store (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_val(upd_val), .q(q)
  );

  generate
    for (genvar i = 0; i < NVIEW; i++) begin : g_view
      trap_ret_view #(.XLEN(XLEN), .ALIGN_CFG(ALIGN_CFG)) u_view (
        .q(q), .align32_on(align32_on), .view(views[i])
      );
    end
  endgenerate

  assign sw_rdata   = views[0];
  assign ret_target = views[1];

  // R2
  bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata[0] == 1'b0) && (ret_target[0] == 1'b0));

  // R3
  fixed32_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ALIGN_CFG == ALN_FIXED32) |-> (sw_rdata[1:0] == 2'b00));

  // R4
  switch_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ALIGN_CFG == ALN_SWITCH) && align32_on) |-> (sw_rdata[1] == 1'b0));

  // R5
  ret_same_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_target == sw_rdata);

  // R8
  capture_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(trap_take)) |-> (q[XLEN-1:2] == $past(trap_pc[XLEN-1:2])));
endmodule

// File: tb/tb_trap_ret_addr.sv
module tb_trap_ret_addr;
  import trap_ret_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  typedef struct packed {
    logic        cap;
    logic [1:0]  op;
    logic [31:0] wd;
    logic [31:0] pc;
    logic        a32;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b01, 32'h8000_0007, 32'h0, 1'b0, 32'h8000_0006},
    '{1'b0, 2'b00, 32'h0,         32'h0, 1'b1, 32'h8000_0004},
    '{1'b0, 2'b00, 32'h0,         32'h0, 1'b0, 32'h8000_0006},
    '{1'b0, 2'b01, 32'h1234_567B, 32'h0, 1'b1, 32'h1234_5678},
    '{1'b0, 2'b00, 32'h0,         32'h0, 1'b0, 32'h1234_567A},
    '{1'b0, 2'b10, 32'h0000_0101, 32'h0, 1'b0, 32'h1234_577A},
    '{1'b0, 2'b11, 32'h0000_0002, 32'h0, 1'b1, 32'h1234_5778},
    '{1'b0, 2'b10, 32'h0000_0002, 32'h0, 1'b1, 32'h1234_5778},
    '{1'b1, 2'b01, 32'h0,         32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEC},
    '{1'b0, 2'b00, 32'h0,         32'h0, 1'b0, 32'hDEAD_BEEE},
    '{1'b1, 2'b00, 32'h0,         32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFE},
    '{1'b0, 2'b11, 32'hFFFF_FFFF, 32'h0, 1'b0, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sw_op = 2'b00;
  logic [31:0] sw_wdata = '0, trap_pc = '0;
  logic trap_take = 1'b0, align32_on = 1'b0;
  logic [31:0] rd_sw, rt_sw, rd_32, rt_32, rd_16, rt_16;
  logic [31:0] m32, m16;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_ret_addr #(.XLEN(XLEN), .ALIGN_CFG(ALN_SWITCH)) dut (
    .clk(clk), .rst_n(rst_n), .sw_op(sw_op), .sw_wdata(sw_wdata), .sw_rdata(rd_sw),
    .trap_take(trap_take), .trap_pc(trap_pc), .align32_on(align32_on), .ret_target(rt_sw));
  trap_ret_addr #(.XLEN(XLEN), .ALIGN_CFG(ALN_FIXED32)) dut32 (
    .clk(clk), .rst_n(rst_n), .sw_op(sw_op), .sw_wdata(sw_wdata), .sw_rdata(rd_32),
    .trap_take(trap_take), .trap_pc(trap_pc), .align32_on(align32_on), .ret_target(rt_32));
  trap_ret_addr #(.XLEN(XLEN), .ALIGN_CFG(ALN_FIXED16)) dut16 (
    .clk(clk), .rst_n(rst_n), .sw_op(sw_op), .sw_wdata(sw_wdata), .sw_rdata(rd_16),
    .trap_take(trap_take), .trap_pc(trap_pc), .align32_on(align32_on), .ret_target(rt_16));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] m, input logic cap,
      input logic [1:0] op, input logic [31:0] wd, input logic [31:0] pc, input logic [31:0] keep);
    logic [31:0] n;
    if (cap) n = pc;
    else case (op)
      2'b01: n = wd;
      2'b10: n = m | wd;
      2'b11: n = m & ~wd;
      default: n = m;
    endcase
    return n & keep;
  endfunction

  task automatic apply(input logic cap, input logic [1:0] op, input logic [31:0] wd,
                       input logic [31:0] pc, input logic a32);
    trap_take = cap; sw_op = op; sw_wdata = wd; trap_pc = pc; align32_on = a32;
    m32 = model_next(m32, cap, op, wd, pc, 32'hFFFF_FFFC);
    m16 = model_next(m16, cap, op, wd, pc, 32'hFFFF_FFFE);
    @(negedge clk);
    trap_take = 1'b0; sw_op = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog actual expired expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m32 = '0; m16 = '0;
    repeat (3) @(negedge clk);
    check("R1 reset sw_rdata", rd_sw, 32'h0);
    check("R1 reset ret_target", rt_sw, 32'h0);
    check("R1 reset fixed32", rd_32, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", rd_sw, 32'h0);

    // Table walk covering R2 R4 R5 R6 R7 R8 R11, and R3 R10 via the fixed builds
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].cap, VEC[i].op, VEC[i].wd, VEC[i].pc, VEC[i].a32);
      check($sformatf("R7 R4 R6 vec %0d sw_rdata", i), rd_sw, VEC[i].exp);
      check($sformatf("R5 vec %0d ret_target", i), rt_sw, VEC[i].exp);
      check($sformatf("R3 vec %0d fixed32", i), rd_32, m32);
      check($sformatf("R3 vec %0d fixed32 ret", i), rt_32, m32);
      check($sformatf("R10 vec %0d fixed16", i), rd_16, m16);
      check($sformatf("R10 vec %0d fixed16 ret", i), rt_16, m16);
    end

    // R9: a read in the write cycle shows the old value
    sw_op = 2'b01; sw_wdata = 32'h0000_00F3; align32_on = 1'b0;
    #1;
    check("R9 same-cycle old value", rd_sw, 32'h0);
    m32 = 32'h0000_00F0; m16 = 32'h0000_00F2;
    @(negedge clk);
    sw_op = 2'b00;
    check("R9 new value after edge", rd_sw, 32'h0000_00F2);

    // R10: align32_on has no effect in the fixed-16 build
    align32_on = 1'b1;
    #1;
    check("R10 fixed16 ignores align32_on", rd_16, 32'h0000_00F2);
    check("R4 switched hides bit1", rd_sw, 32'h0000_00F0);

    // R2: all-ones write leaves bit 0 clear
    apply(1'b0, 2'b01, 32'hFFFF_FFFF, 32'h0, 1'b0);
    check("R2 bit0 zero after all-ones", rd_sw, 32'hFFFF_FFFE);
    check("R3 fixed32 after all-ones", rd_32, 32'hFFFF_FFFC);

    // R1: reset mid-run clears the register
    rst_n = 1'b0;
    #1;
    check("R1 async reset clears", rd_sw, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule